// File: doc/BRIEF.md
# Reconfigurable Johnson Test-Pattern Generator

This block is a 10-bit on-chip stimulus source for a scan chain or a circuit under test. On every enabled clock it either takes a seed word from a memory-side parallel input or advances as a twisted-ring counter whose ring has two extra XOR feedback points inside it. Because of those inserted taps the register does not walk the plain 2N Johnson cycle; each seed opens a different trajectory.

A single select input picks the source of the next vector, an enable gates every state change, and a synchronous reset clears the register. The whole register is visible on a parallel output, and the top stage doubles as a serial output for feeding a scan chain one bit per clock.

Top module: `rjtg_top`

## Requirements
- R1: A synchronous reset (rst = 1 at a rising clock edge) clears all ten stages to 0, regardless of en and load_sel.
- R2: With rst = 0 and en = 0 at a rising edge the register keeps its value, whatever load_sel and seed_in are.
- R3: With rst = 0, en = 1 and load_sel = 1 at a rising edge, the register takes the value of seed_in (bit i of seed_in into stage i).
- R4: With rst = 0, en = 1 and load_sel = 0 (counting), stage 0 takes the inverse of stage 9.
- R5: When counting, stage 2 takes stage 0 XOR stage 9.
- R6: When counting, stage 3 takes stage 9 XOR stage 5.
- R7: When counting, every stage i in {1, 4, 5, 6, 7, 8, 9} takes the previous value of stage i-1.
- R8: vec_out shows the full register after every clock edge (bit i is stage i) and scan_out always equals stage 9.
- R9: Counting from the all-zero state gives 0x001 after one enabled clock and 0x007 after the second, and 0x007 then repeats under further counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| en | input | 1 | Enables any state change when high |
| load_sel | input | 1 | 1 = load seed_in, 0 = advance the counter |
| seed_in | input | 10 | Seed word from the pattern memory |
| vec_out | output | 10 | Current register contents |
| scan_out | output | 1 | Serial output, the top stage |

## Verification
Counting is run from several unrelated seeds, including the all-zero state whose trajectory collapses into the fixed point 0x007 and patterns with stage 5 or stage 9 set, so that a swapped or missing XOR tap shows up as a wrong bit 2 or bit 3 instead of staying hidden behind zeros. Hold cycles are driven with load_sel high and a seed different from the register, which separates a correct enable gate from one that lets the load through. Reset is asserted together with enable and load, telling reset priority apart from a load. A long random mix of reset, hold, load and count operations is compared each cycle against a model written from the next-state rules.

// File: rtl/rjtg_pkg.sv
package rjtg_pkg;

   typedef enum logic {
      SRC_COUNT = 1'b0,
      SRC_SEED  = 1'b1
   } src_sel_e;

endpackage

// File: rtl/rjtg_stage.sv
module rjtg_stage
   import rjtg_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     en,
   input  src_sel_e sel,
   input  logic     cnt_d,
   input  logic     seed_d,
   output logic     q
);

   logic d_mux;

   always_comb begin
      d_mux = (sel == SRC_SEED) ? seed_d : cnt_d;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= 1'b0;
      end else if (en) begin
         q <= d_mux;
      end
   end

endmodule

// File: rtl/rjtg_feedback.sv
module rjtg_feedback #(
   parameter int WIDTH      = 10,
   parameter int TAPA_STAGE = 2,
   parameter int TAPA_SRC   = 0,
   parameter int TAPB_STAGE = 3,
   parameter int TAPB_SRC   = 5,
   parameter bit TWIST      = 1'b1
) (
   input  logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] nxt
);

   localparam int TOP = WIDTH - 1;

   logic top_bit;
   assign top_bit = q[TOP];

   generate
      if (TWIST) begin : g_twist
         assign nxt[0] = ~top_bit;
      end else begin : g_ring
         assign nxt[0] = top_bit;
      end

      for (genvar i = 1; i < WIDTH; i++) begin : g_bit
         if (i == TAPA_STAGE) begin : g_tapa
            assign nxt[i] = q[TAPA_SRC] ^ top_bit;
         end else if (i == TAPB_STAGE) begin : g_tapb
            assign nxt[i] = top_bit ^ q[TAPB_SRC];
         end else begin : g_shift
            assign nxt[i] = q[i-1];
         end
      end
   endgenerate

endmodule

// File: rtl/rjtg_top.sv
module rjtg_top
   import rjtg_pkg::*;
#(
   parameter int WIDTH      = 10,
   parameter int TAPA_STAGE = 2,
   parameter int TAPA_SRC   = 0,
   parameter int TAPB_STAGE = 3,
   parameter int TAPB_SRC   = 5,
   parameter bit TWIST      = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             load_sel,
   input  logic [WIDTH-1:0] seed_in,
   output logic [WIDTH-1:0] vec_out,
   output logic             scan_out
);

   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 4) begin : g_bad_width
         $error("rjtg_top: WIDTH must be at least 4");
      end
      if (TAPA_STAGE < 1 || TAPA_STAGE > TOP || TAPB_STAGE < 1 || TAPB_STAGE > TOP) begin : g_bad_stage
         $error("rjtg_top: tap stages must lie in 1..WIDTH-1");
      end
      if (TAPA_STAGE == TAPB_STAGE) begin : g_same_stage
         $error("rjtg_top: tap stages must differ");
      end
      if (TAPA_SRC < 0 || TAPA_SRC > TOP || TAPB_SRC < 0 || TAPB_SRC > TOP) begin : g_bad_src
         $error("rjtg_top: tap sources must lie in 0..WIDTH-1");
      end
   endgenerate

   src_sel_e         sel;
   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] cnt_nxt;

   assign sel = src_sel_e'(load_sel);

   rjtg_feedback #(
      .WIDTH      (WIDTH),
      .TAPA_STAGE (TAPA_STAGE),
      .TAPA_SRC   (TAPA_SRC),
      .TAPB_STAGE (TAPB_STAGE),
      .TAPB_SRC   (TAPB_SRC),
      .TWIST      (TWIST)
   ) fb_i (
      .q   (state_q),
      .nxt (cnt_nxt)
   );

   generate
      for (genvar s = 0; s < WIDTH; s++) begin : g_stage
         rjtg_stage stage_i (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .sel    (sel),
            .cnt_d  (cnt_nxt[s]),
            .seed_d (seed_in[s]),
            .q      (state_q[s])
         );
      end
   endgenerate

   assign vec_out  = state_q;
   assign scan_out = state_q[TOP];

endmodule

// File: rtl/rjtg_chk.sv
module rjtg_chk #(
   parameter int WIDTH      = 10,
   parameter int TAPA_STAGE = 2,
   parameter int TAPA_SRC   = 0,
   parameter int TAPB_STAGE = 3,
   parameter int TAPB_SRC   = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic             load_sel,
   input logic [WIDTH-1:0] seed_in,
   input logic [WIDTH-1:0] vec_out,
   input logic             scan_out
);

   localparam int TOP = WIDTH - 1;

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (vec_out == '0));

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(vec_out));

   p_seed_load_r3: assert property (@(posedge clk) disable iff (rst)
      (en && load_sel) |=> (vec_out == $past(seed_in)));

   p_twist_r4: assert property (@(posedge clk) disable iff (rst)
      (en && !load_sel) |=> (vec_out[0] == !$past(vec_out[TOP])));

   p_tapa_r5: assert property (@(posedge clk) disable iff (rst)
      (en && !load_sel) |=> (vec_out[TAPA_STAGE] == ($past(vec_out[TAPA_SRC]) ^ $past(vec_out[TOP]))));

   p_tapb_r6: assert property (@(posedge clk) disable iff (rst)
      (en && !load_sel) |=> (vec_out[TAPB_STAGE] == ($past(vec_out[TOP]) ^ $past(vec_out[TAPB_SRC]))));

   p_serial_r8: assert property (@(posedge clk) disable iff (rst)
      en |=> (scan_out == vec_out[TOP]));

   generate
      for (genvar i = 1; i < WIDTH; i++) begin : g_shift_chk
         if (i != TAPA_STAGE && i != TAPB_STAGE) begin : g_plain
            p_shift_r7: assert property (@(posedge clk) disable iff (rst)
               (en && !load_sel) |=> (vec_out[i] == $past(vec_out[i-1])));
         end
      end
   endgenerate

endmodule

bind rjtg_top rjtg_chk #(
   .WIDTH      (WIDTH),
   .TAPA_STAGE (TAPA_STAGE),
   .TAPA_SRC   (TAPA_SRC),
   .TAPB_STAGE (TAPB_STAGE),
   .TAPB_SRC   (TAPB_SRC)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .load_sel (load_sel),
   .seed_in  (seed_in),
   .vec_out  (vec_out),
   .scan_out (scan_out)
);

// File: tb/rjtg_top_tb_top.sv
module rjtg_top_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       load_sel = 1'b0;
   logic [9:0] seed_in = '0;
   logic [9:0] vec_out;
   logic       scan_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [9:0] model = '0;

   always #10 clk = ~clk;

   rjtg_top dut_i (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .load_sel (load_sel),
      .seed_in  (seed_in),
      .vec_out  (vec_out),
      .scan_out (scan_out)
   );

   function automatic logic [9:0] count_next(logic [9:0] q);
      logic [9:0] n;
      n[0] = ~q[9];
      n[1] = q[0];
      n[2] = q[0] ^ q[9];
      n[3] = q[9] ^ q[5];
      for (int i = 4; i < 10; i++) n[i] = q[i-1];
      return n;
   endfunction

   task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at negedge, sample 1 ns after the following posedge
   task automatic step(logic r, logic e, logic l, logic [9:0] s);
      string tag;
      @(negedge clk);
      rst = r; en = e; load_sel = l; seed_in = s;
      @(posedge clk);
      #1;
      if (r) begin
         model = '0; tag = "R1";
      end else if (!e) begin
         tag = "R2";
      end else if (l) begin
         model = s; tag = "R3";
      end else begin
         model = count_next(model); tag = "count";
      end
      if (tag == "count") begin
         chk("R4 bit0", {9'd0, vec_out[0]}, {9'd0, model[0]});
         chk("R5 bit2", {9'd0, vec_out[2]}, {9'd0, model[2]});
         chk("R6 bit3", {9'd0, vec_out[3]}, {9'd0, model[3]});
         chk("R7 shift", vec_out & 10'h3F2, model & 10'h3F2);
      end else begin
         chk(tag, vec_out, model);
      end
      chk("R8 serial", {9'd0, scan_out}, {9'd0, model[9]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned r;
      logic [9:0] seeds [3];
      void'($urandom(32'd1357));

      step(1, 0, 0, '0);
      chk("R1 reset state", vec_out, 10'h000);

      // R9: fixed point from zero
      step(0, 1, 0, '0);
      chk("R9 first count", vec_out, 10'h001);
      step(0, 1, 0, '0);
      chk("R9 second count", vec_out, 10'h007);
      step(0, 1, 0, '0);
      chk("R9 fixed point", vec_out, 10'h007);

      // R3 load then R2 hold with a different seed offered
      step(0, 1, 1, 10'h3A5);
      chk("R3 load", vec_out, 10'h3A5);
      step(0, 0, 1, 10'h05A);
      chk("R2 hold with load", vec_out, 10'h3A5);
      step(0, 0, 0, 10'h05A);
      chk("R2 hold with count", vec_out, 10'h3A5);

      // R1 priority over load
      step(1, 1, 1, 10'h3FF);
      chk("R1 priority", vec_out, 10'h000);

      // counting from several seeds, 45 cycles each
      seeds[0] = 10'h200; seeds[1] = 10'h020; seeds[2] = 10'h2C9;
      foreach (seeds[k]) begin
         step(0, 1, 1, seeds[k]);
         for (int c = 0; c < 45; c++) step(0, 1, 0, 10'h155);
      end

      // constrained random mix
      for (int c = 0; c < 600; c++) begin
         r = $urandom_range(0, 99);
         if (r < 3)       step(1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 10'($urandom));
         else if (r < 18) step(0, 0, $urandom_range(0, 1) == 1, 10'($urandom));
         else if (r < 33) step(0, 1, 1, 10'($urandom));
         else             step(0, 1, 0, 10'($urandom));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule